// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. When a burst opens, it captures the whole external address. The low two bits of that address become the first beat. Each later continuation cycle moves the low bits to the next beat. The upper bits stay at the captured value for the whole burst.

A static strap input picks one of two beat orderings:

- **Interleaved:** the starting low bits are XOR-ed with a beat counter that runs 0, 1, 2, 3.
- **Linear:** one is added to the starting low bits on each beat, modulo four.

A stall input freezes the sequencer completely. Continuation cycles after the fourth beat wrap around inside the same four-address group. A new external address is only taken at the next burst start.

The control is a two-state machine:

- `ST_IDLE` is the state after reset, before any burst has opened. The output is zero.
- `ST_BURST` is the state once any burst has opened.

Its transitions are:

- `IDLE->BURST` is taken on an unstalled start.
- `BURST->BURST` is taken on every later cycle. An unstalled start reloads the address and restarts the beat count.
- There is no path back to `ST_IDLE` other than reset.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low and after its release with no start, `addr_out` is all zeros and `in_burst` is 0.
- R2: A cycle with `start`=1 and `stall`=0 makes `addr_out` equal to that cycle's `addr_in` after the clock edge, with `in_burst`=1. This is beat 0, and the beat count restarts at zero.
- R3: With `interleave`=1, the low two bits on beat k are the start low bits XOR k. For example, start 01 gives 01, 00, 11, 10.
- R4: With `interleave`=0, the low two bits on beat k are (start low bits + k) mod 4. For example, start 10 gives 10, 11, 00, 01.
- R5: A cycle with `stall`=1 leaves `addr_out` and `in_burst` unchanged, whatever `start`, `advance` and `addr_in` are.
- R6: An unstalled `advance` moves to the next beat. After beat 3 it wraps to beat 0 of the same group, so the fifth beat equals the first.
- R7: The upper bits of `addr_out` (bits ADDR_W-1 down to 2) keep the value loaded at the burst start until the next unstalled start.
- R8: When `start` and `advance` are both 1 in an unstalled cycle, the start wins. The new address is loaded as beat 0.
- R9: `advance` in `ST_IDLE` is ignored: `addr_out` stays zero and `in_burst` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | 1 freezes all state for this cycle |
| start | input | 1 | 1 opens a burst at `addr_in` |
| advance | input | 1 | 1 steps to the next beat |
| interleave | input | 1 | Ordering strap: 1 interleaved, 0 linear |
| addr_in | input | ADDR_W | External starting address |
| addr_out | output | ADDR_W | Current burst address |
| in_burst | output | 1 | 1 once a burst has been opened (state `ST_BURST`) |

## Verification
The hardest situation to reach from the ports is a stalled cycle that carries a competing start with a different address in the middle of a burst. Only after it is the wrapped fifth beat in view. The bench sweeps both orderings and all four starting low values. In each burst it runs five advances with a stalled start-and-advance cycle inserted after beat 2. It also sends one unstalled start-with-advance to confirm the reload. The expected addresses are computed arithmetically from the start value and the beat number.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } seq_state_t;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int BURST_LEN = 4,
    localparam int CW = $clog2(BURST_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          clear,
    input  logic          step,
    output logic [CW-1:0] beat
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else if (!hold) begin
            if (clear)
                beat <= '0;
            else if (step)
                beat <= beat + CW'(1);
        end
    end

    // R5
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(beat));

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && clear) |=> (beat == '0));

    // R6
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !clear && step) |=> (beat == CW'($past(beat) + CW'(1))));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
    parameter int LW = 2
) (
    input  logic          interleave,
    input  logic [LW-1:0] base,
    input  logic [LW-1:0] beat,
    output logic [LW-1:0] low
);
    always_comb begin
        if (interleave)
            low = base ^ beat;
        else
            low = base + beat;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              start,
    input  logic              advance,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              in_burst
);
    localparam int LW = $clog2(BURST_LEN);
    localparam int UW = ADDR_W - LW;

    seq_state_t     state_q, state_d;
    logic [LW-1:0]  base_q;
    logic [UW-1:0]  upper_q;
    logic [LW-1:0]  beat;
    logic [LW-1:0]  low;
    logic           load;
    logic           step_en;

    assign load    = start && !stall;
    assign step_en = advance && (state_q == ST_BURST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load) state_d = ST_BURST;
            ST_BURST: state_d = ST_BURST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            upper_q <= '0;
        end else begin
            state_q <= state_d;
            if (load) begin
                base_q  <= addr_in[LW-1:0];
                upper_q <= addr_in[ADDR_W-1:LW];
            end
        end
    end

    burst_beat_ctr #(.BURST_LEN(BURST_LEN)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (stall),
        .clear (start),
        .step  (step_en),
        .beat  (beat)
    );

    burst_order_map #(.LW(LW)) u_map (
        .interleave (interleave),
        .base       (base_q),
        .beat       (beat),
        .low        (low)
    );

    always_comb begin
        addr_out = {upper_q, low};
        in_burst = (state_q == ST_BURST);
    end

    // R2
    load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !stall) |=> (addr_out == $past(addr_in)) && in_burst);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_burst |-> (addr_out == '0));

    // R7
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start || stall) |=> $stable(addr_out[ADDR_W-1:LW]));

    // R5
    stall_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(in_burst));
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          stall, start, advance, interleave;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic          in_burst;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(4)) u0 (
        .clk(clk), .rst_n(rst_n), .stall(stall), .start(start),
        .advance(advance), .interleave(interleave), .addr_in(addr_in),
        .addr_out(addr_out), .in_burst(in_burst)
    );

    task automatic check(input string req, input logic [AW-1:0] exp_a,
                         input logic exp_b);
        n_chk++;
        if (addr_out !== exp_a || in_burst !== exp_b) begin
            n_bad++;
            $display("FAIL %s: addr_out=%h in_burst=%b expected addr_out=%h in_burst=%b",
                     req, addr_out, in_burst, exp_a, exp_b);
        end
    endtask

    task automatic cyc(input logic s, input logic st, input logic adv,
                       input logic [AW-1:0] a);
        @(negedge clk);
        stall = s; start = st; advance = adv; addr_in = a;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [1:0] exp_low(input logic m, input logic [1:0] b,
                                          input int k);
        logic [1:0] kk;
        kk = 2'(k % 4);
        return m ? (b ^ kk) : 2'((int'(b) + k) % 4);
    endfunction

    initial begin
        #2000000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        logic [1:0]    lo;
        rst_n = 1'b0; stall = 0; start = 0; advance = 0; interleave = 1; addr_in = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", '0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        cyc(0, 0, 0, 8'hFF);
        check("R1 idle after reset", '0, 1'b0);
        cyc(0, 0, 1, 8'hA5);
        check("R9 advance in idle", '0, 1'b0);
        cyc(1, 1, 0, 8'h77);
        check("R5 stalled start in idle", '0, 1'b0);

        for (int m = 0; m < 2; m++) begin
            interleave = m[0];
            for (int s = 0; s < 4; s++) begin
                a = {6'(m * 20 + s * 7 + 3), 2'(s)};
                cyc(0, 1, 0, a);
                check("R2 load", a, 1'b1);
                for (int k = 1; k <= 5; k++) begin
                    cyc(0, 0, 1, ~a);
                    lo = exp_low(m[0], 2'(s), k);
                    check(m ? (k > 3 ? "R6 wrap interleaved" : "R3 interleaved")
                            : (k > 3 ? "R6 wrap linear" : "R4 linear"),
                          {a[AW-1:2], lo}, 1'b1);
                    if (k == 2) begin
                        cyc(1, 1, 1, ~a);
                        check("R5 stall holds", {a[AW-1:2], lo}, 1'b1);
                        check("R7 upper kept", {a[AW-1:2], lo}, 1'b1);
                    end
                end
                cyc(0, 1, 1, a ^ 8'h5C);
                check("R8 start beats advance", a ^ 8'h5C, 1'b1);
                cyc(0, 0, 1, 8'h00);
                lo = exp_low(m[0], (a[1:0] ^ 2'b00), 1);
                check("R8 beat restart", {(a[AW-1:2] ^ 6'h17), lo}, 1'b1);
            end
        end

        interleave = 1;
        cyc(0, 1, 0, 8'h01);
        for (int k = 1; k < 4; k++) begin
            cyc(0, 0, 1, 8'h00);
            check("R3 from 01", {6'h00, exp_low(1'b1, 2'b01, k)}, 1'b1);
        end
        interleave = 0;
        cyc(0, 1, 0, 8'h02);
        for (int k = 1; k < 4; k++) begin
            cyc(0, 0, 1, 8'h00);
            check("R4 from 10", {6'h00, exp_low(1'b0, 2'b10, k)}, 1'b1);
        end

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule